// File: doc/BRIEF.md
# Refresh Window Compliance Monitor

This block watches a one-bit refresh strobe and checks that every sliding span of `WIN_CYC` clock cycles holds at least `REQ_CNT` refreshes. It checks every window position, not only back-to-back aligned windows. A refresh schedule can meet the count in each fixed window and still leave gaps when it moves from one pattern to another, for example from a burst followed by a long pause to evenly spaced refreshes. The monitor catches those gaps.

The monitor stores the arrival cycle of up to `REQ_CNT` recent refreshes. A refresh counts toward the window for exactly `WIN_CYC` cycles after it arrives, and then it ages out. The reported count is therefore the number of refreshes in the most recent `WIN_CYC` cycles, capped at `REQ_CNT`. No check is made until one full window has passed since reset. After that, each failing window position gives a one-cycle violation pulse and sets an error flag that stays set until reset. Both parameters are in clock cycles, and both must be at least 2.

Top module: `rfm_window_mon`

## Requirements
- R1: Each cycle in which `ref_strobe` is high at the rising edge counts as one refresh. After the edge that samples cycle k (k = 0 is the first edge with `rst_n` high), `win_count` equals the number of refreshes sampled in cycles k-WIN_CYC+1 through k, capped at REQ_CNT.
- R2: A refresh sampled in cycle c still counts after the edge of cycle c+WIN_CYC-1. It no longer counts after the edge of cycle c+WIN_CYC.
- R3: `win_count` never exceeds REQ_CNT. Extra refreshes while the window is full leave it at REQ_CNT.
- R4: When one refresh enters the window on the same edge that another ages out, `win_count` is unchanged.
- R5: `viol_pulse` stays low after the edges of cycles 0 through WIN_CYC-2 since reset, whatever the count.
- R6: From the edge of cycle WIN_CYC-1 onward, `viol_pulse` is high for exactly the cycles in which `win_count` is below REQ_CNT. Each failing window position gives one pulse cycle.
- R7: `err_sticky` goes high together with the first `viol_pulse` and stays high until reset.
- R8: Evenly spaced refreshes, one every WIN_CYC/REQ_CNT cycles starting at cycle 0, never raise a violation.
- R9: A burst of REQ_CNT back-to-back refreshes, followed at once by evenly spaced ones, passes in every window position. If the evenly spaced refreshes only start after a pause that ends a full window after the burst began, the monitor flags several window positions.
- R10: While `rst_n` is low at a rising edge, the monitor forgets all stored refreshes and drives `win_count`, `viol_pulse` and `err_sticky` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_strobe | input | 1 | High in a cycle to mark one refresh command |
| win_count | output | $clog2(REQ_CNT+1) | Refreshes in the most recent WIN_CYC cycles, capped at REQ_CNT |
| viol_pulse | output | 1 | High for one cycle per window position with too few refreshes |
| err_sticky | output | 1 | Set by the first violation, cleared only by reset |

## Verification
The assertions assume three things: the strobe is a clean level sampled once per cycle, reset is held low for at least two rising edges, and the parameters are at least 2. With those in place, the checks on count steps and on the warm-up window start from a known state. The bench holds reset for three edges, changes the strobe only on falling clock edges, and keeps each scenario short enough that the cycle index from reset stays within its history store. It checks the count, pulse and flag every cycle against a window sum computed from the strobes it drove.

// File: rtl/rfm_pkg.sv
// Package: rfm_pkg
// Shared types and helpers for the refresh window monitor.
// Assumes: nothing beyond standard elaboration-time integer math.
package rfm_pkg;

    // Operation chosen for the timestamp store in one cycle.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,   // nothing enters, nothing ages out
        OP_PUSH = 2'd1,   // one stamp enters, none leaves
        OP_POP  = 2'd2,   // the oldest stamp ages out
        OP_SWAP = 2'd3    // one enters while one leaves (aged or displaced)
    } fifo_op_e;

    // Width of an index able to address v entries (at least 1 bit).
    function automatic int unsigned idx_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/rfm_tick.sv
// Module: rfm_tick
// Free-running cycle stamp plus a warm-up tracker that reports when
// the current edge is at least WIN_CYC-1 cycles past reset.
// Assumes: WIN_CYC >= 2 and TW wide enough to hold WIN_CYC.
module rfm_tick #(
    parameter int WIN_CYC = 256,
    parameter int TW      = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] now_o,
    output logic          armed_o
);
    localparam logic [TW-1:0] LAST_AGE = TW'(WIN_CYC - 1);

    logic [TW-1:0] stamp_q;
    logic [TW-1:0] age_q;

    // Cycle stamp: wraps freely; only differences are used downstream.
    always_ff @(posedge clk) begin
        if (!rst_n) stamp_q <= '0;
        else        stamp_q <= stamp_q + 1'b1;
    end

    // Warm-up count: edges since reset, saturating at WIN_CYC-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                 age_q <= '0;
        else if (age_q != LAST_AGE) age_q <= age_q + 1'b1;
    end

    assign now_o   = stamp_q;
    assign armed_o = (age_q == LAST_AGE);
endmodule

// File: rtl/rfm_stamp_fifo.sv
// Module: rfm_stamp_fifo
// Circular store of the arrival stamps of the newest DEPTH refreshes.
// The oldest stamp leaves once it is exactly WIN_CYC cycles old; when
// full, a new arrival displaces the oldest so occupancy caps at DEPTH.
// Assumes: at most one arrival per cycle, so stamps are distinct and
// at most one can age out per cycle; DEPTH >= 2.
module rfm_stamp_fifo
    import rfm_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int WIN_CYC = 256,
    parameter int TW      = 9,
    parameter int CW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [TW-1:0] now_i,
    output logic [CW-1:0] occ_o,
    output logic [CW-1:0] occ_next_o
);
    localparam int             PW       = idx_bits(DEPTH);
    localparam logic [CW-1:0]  FULL     = CW'(DEPTH);
    localparam logic [PW-1:0]  LAST_IDX = PW'(DEPTH - 1);
    localparam logic [TW-1:0]  SPAN     = TW'(WIN_CYC);

    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] occ_q, occ_d;
    logic [TW-1:0] slot_w [DEPTH];
    logic [TW-1:0] head_ts;
    logic          expire;
    logic          wr_en, rd_adv;
    fifo_op_e      op;

    // Advance a ring index with wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Storage cells: one stamp register per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [TW-1:0] cell_q;
        // Capture the current stamp when this slot is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)                           cell_q <= '0;
            else if (wr_en && wr_q == PW'(g))     cell_q <= now_i;
        end
        assign slot_w[g] = cell_q;
    end

    assign head_ts = slot_w[rd_q];
    assign expire  = (occ_q != '0) && ((now_i - head_ts) == SPAN);

    // Pick the store operation for this cycle.
    always_comb begin
        unique case ({push_i, expire})
            2'b11:   op = OP_SWAP;
            2'b10:   op = (occ_q == FULL) ? OP_SWAP : OP_PUSH;
            2'b01:   op = OP_POP;
            default: op = OP_HOLD;
        endcase
    end

    assign wr_en  = (op == OP_PUSH) || (op == OP_SWAP);
    assign rd_adv = (op == OP_POP)  || (op == OP_SWAP);

    // Next occupancy from the chosen operation.
    always_comb begin
        unique case (op)
            OP_PUSH: occ_d = occ_q + 1'b1;
            OP_POP:  occ_d = occ_q - 1'b1;
            default: occ_d = occ_q;
        endcase
    end

    // Ring pointers and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            if (wr_en)  wr_q <= bump(wr_q);
            if (rd_adv) rd_q <= bump(rd_q);
            occ_q <= occ_d;
        end
    end

    assign occ_o      = occ_q;
    assign occ_next_o = occ_d;
endmodule

// File: rtl/rfm_judge.sv
// Module: rfm_judge
// Turns the post-edge window count into a per-position violation
// pulse and a sticky error flag, once the warm-up window is over.
// Assumes: occ_next_i is the count that the store holds after this edge.
module rfm_judge #(
    parameter int REQ_CNT = 16,
    parameter int CW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          armed_i,
    input  logic [CW-1:0] occ_next_i,
    output logic          viol_o,
    output logic          err_o
);
    localparam logic [CW-1:0] NEED = CW'(REQ_CNT);

    logic short_now;
    logic viol_q, err_q;

    assign short_now = armed_i && (occ_next_i < NEED);

    // Register the pulse and accumulate the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            viol_q <= short_now;
            err_q  <= err_q | short_now;
        end
    end

    assign viol_o = viol_q;
    assign err_o  = err_q;
endmodule

// File: rtl/rfm_window_mon.sv
// Module: rfm_window_mon (top)
// Checks that every sliding span of WIN_CYC cycles holds at least
// REQ_CNT refresh strobes; reports the capped count, a violation pulse
// per failing window position and a sticky error flag.
// Assumes: REQ_CNT >= 2, WIN_CYC >= 2, one refresh per strobe cycle.
module rfm_window_mon #(
    parameter int REQ_CNT = 16,
    parameter int WIN_CYC = 256,
    localparam int TW = $clog2(WIN_CYC + 1),
    localparam int CW = $clog2(REQ_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_strobe,
    output logic [CW-1:0] win_count,
    output logic          viol_pulse,
    output logic          err_sticky
);
    logic [TW-1:0] now_w;
    logic          armed_w;
    logic [CW-1:0] occ_w, occ_next_w;

    rfm_tick #(.WIN_CYC(WIN_CYC), .TW(TW)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .now_o   (now_w),
        .armed_o (armed_w)
    );

    rfm_stamp_fifo #(.DEPTH(REQ_CNT), .WIN_CYC(WIN_CYC), .TW(TW), .CW(CW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ref_strobe),
        .now_i      (now_w),
        .occ_o      (occ_w),
        .occ_next_o (occ_next_w)
    );

    rfm_judge #(.REQ_CNT(REQ_CNT), .CW(CW)) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed_i    (armed_w),
        .occ_next_i (occ_next_w),
        .viol_o     (viol_pulse),
        .err_o      (err_sticky)
    );

    assign win_count = occ_w;
endmodule

// File: rtl/rfm_window_mon_chk.sv
// Module: rfm_window_mon_chk
// Port-level properties of the refresh window monitor, bound to the top.
// Assumes: reset is held for at least two edges before checks apply.
module rfm_window_mon_chk #(
    parameter int REQ_CNT = 16,
    parameter int WIN_CYC = 256,
    localparam int TW = $clog2(WIN_CYC + 1),
    localparam int CW = $clog2(REQ_CNT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_strobe,
    input logic [CW-1:0] win_count,
    input logic          viol_pulse,
    input logic          err_sticky
);
    localparam logic [CW-1:0] NEED = CW'(REQ_CNT);
    localparam logic [TW-1:0] SPAN = TW'(WIN_CYC);

    logic          prev_run_q = 1'b0;
    logic [TW-1:0] seen_q     = '0;
    logic          live;

    // Remember whether the previous edge was out of reset.
    always_ff @(posedge clk) prev_run_q <= rst_n;

    // Edges since reset, saturating at WIN_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)              seen_q <= '0;
        else if (seen_q != SPAN) seen_q <= seen_q + 1'b1;
    end

    assign live = rst_n && prev_run_q;

    p_cap_r3: assert property (@(posedge clk) disable iff (!live)
        win_count <= NEED);

    p_unit_step_r4: assert property (@(posedge clk) disable iff (!live)
        ({1'b0, win_count} + 1'b1 >= {1'b0, $past(win_count)}) &&
        ({1'b0, win_count} <= {1'b0, $past(win_count)} + 1'b1));

    p_quiet_no_rise_r2: assert property (@(posedge clk) disable iff (!live)
        !$past(ref_strobe) |-> (win_count <= $past(win_count)));

    p_no_early_flag_r5: assert property (@(posedge clk) disable iff (!live)
        viol_pulse |-> (seen_q == SPAN));

    p_flag_when_short_r6: assert property (@(posedge clk) disable iff (!live)
        (seen_q == SPAN) |-> (viol_pulse == (win_count < NEED)));

    p_pulse_sets_flag_r7: assert property (@(posedge clk) disable iff (!live)
        viol_pulse |-> err_sticky);

    p_flag_holds_r7: assert property (@(posedge clk) disable iff (!live)
        err_sticky |=> err_sticky);
endmodule

bind rfm_window_mon rfm_window_mon_chk #(.REQ_CNT(REQ_CNT), .WIN_CYC(WIN_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_strobe (ref_strobe),
    .win_count  (win_count),
    .viol_pulse (viol_pulse),
    .err_sticky (err_sticky)
);

// File: tb/sim_rfm_window_mon.sv
`timescale 1ns/1ps
// Bench: directed scenarios against a window-sum model of the strobes driven.
module sim_rfm_window_mon;
    localparam int R  = 8;
    localparam int W  = 64;
    localparam int CW = $clog2(R + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe = 1'b0;
    logic [CW-1:0] cnt;
    logic          viol, err;

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    int pulses = 0;
    bit exp_err = 1'b0;
    bit done    = 1'b0;
    bit hist [0:1023];

    always #2 clk = ~clk;

    rfm_window_mon #(.REQ_CNT(R), .WIN_CYC(W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_strobe (strobe),
        .win_count  (cnt),
        .viol_pulse (viol),
        .err_sticky (err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reset for three edges, check the cleared outputs, restart the model.
    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        strobe = 1'b0;
        repeat (3) @(negedge clk);
        chk(cnt == 0,  "R10 count cleared",   int'(cnt),  0);
        chk(viol == 0, "R10 pulse cleared",   int'(viol), 0);
        chk(err == 0,  "R10 flag cleared",    int'(err),  0);
        for (int i = 0; i < 1024; i++) hist[i] = 1'b0;
        k = 0; pulses = 0; exp_err = 1'b0;
        rst_n = 1'b1;
    endtask

    // One cycle: drive the strobe, then compare all outputs with the model.
    task automatic step(input bit s);
        int e;
        bit ev;
        strobe  = s;
        hist[k] = s;
        @(posedge clk);
        @(negedge clk);
        e = 0;
        for (int j = ((k - W + 1) < 0) ? 0 : (k - W + 1); j <= k; j++) e += int'(hist[j]);
        if (e > R) e = R;
        ev = (k >= W - 1) && (e < R);
        exp_err = exp_err | ev;
        chk(int'(cnt) == e, "R1 window count", int'(cnt), e);
        chk(viol == ev, (k < W - 1) ? "R5 no flag in warm-up" : "R6 violation pulse",
            int'(viol), int'(ev));
        chk(err == exp_err, "R7 sticky flag", int'(err), int'(exp_err));
        if (viol) pulses++;
        k++;
        strobe = 1'b0;
    endtask

    task automatic t_regular();
        do_reset();
        for (int i = 0; i < 256; i++) step(i % (W / R) == 0);
        chk(err == 0, "R8 evenly spaced never flags", int'(err), 0);
    endtask

    task automatic t_burst_then_even();
        do_reset();
        for (int i = 0; i < 256; i++) step(i < R || (i >= 15 && (i - 15) % 8 == 0));
        chk(err == 0, "R9 even start right after burst passes", int'(err), 0);
    endtask

    task automatic t_pause_then_even();
        do_reset();
        for (int i = 0; i < 256; i++) step(i < R || (i >= 71 && (i - 71) % 8 == 0));
        chk(err == 1, "R9 even start after pause flagged", int'(err), 1);
        chk(pulses > 1, "R6 several window positions flagged", pulses, 2);
        for (int i = 0; i < 20; i++) step(1'b1);
        chk(err == 1, "R7 flag survives compliant windows", int'(err), 1);
    endtask

    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 40; i++) step(1'b1);
        chk(int'(cnt) == R, "R3 count capped", int'(cnt), R);
        for (int i = 0; i < 10; i++) step(1'b0);
        chk(int'(cnt) == R, "R3 capped count kept in window", int'(cnt), R);
    endtask

    task automatic t_expiry();
        do_reset();
        for (int i = 0; i < 70; i++) begin
            step(i == 0);
            if (i == W - 1) chk(cnt == 1, "R2 counted at last window cycle", int'(cnt), 1);
            if (i == W)     chk(cnt == 0, "R2 aged out after window", int'(cnt), 0);
        end
    endtask

    task automatic t_swap();
        do_reset();
        for (int i = 0; i < 70; i++) begin
            step(i == 0 || i == W);
            if (i == W) chk(cnt == 1, "R4 enter and age out together", int'(cnt), 1);
        end
    endtask

    initial begin
        t_regular();
        t_burst_then_even();
        t_pause_then_even();
        t_saturate();
        t_expiry();
        t_swap();
        do_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule